// File: doc/BRIEF.md
# Dual-Bank Normal/Fast Interrupt Controller

This block collects a set of level-sensitive interrupt request lines from peripherals, one dedicated fast request line and a software-writable request register, and turns them into two request outputs for a processor: a normal interrupt request and a fast interrupt request. Both outputs are active low; all request inputs are active high.

Software works with two independent 32-bit register banks, each on its own simple synchronous bus (byte address, write enable, write data, combinational read data). The normal bank reports raw and masked status of the 32 source lines merged with the software register, holds an enable mask that changes only through write-one-to-set and write-one-to-clear offsets, and accepts writes to the software request register. The fast bank offers the same status and enable view for the single fast line and has no software register.

Source lines pass through one sampling register before they reach status and masking. Each output is registered from the masked status, so a change in a source shows in status one edge after it is applied and at the output one edge later.

Top module: `intc_dual_bank`

## Requirements
- R1: While rst_ni is low, both enable masks and the software register are 0, irq_n_o and fiq_n_o are 1, and every read returns 0.
- R2: A normal-bank read at byte offset 0x4 returns the sampled source lines ORed with the software register; the sample is taken at each rising clock edge.
- R3: A normal-bank read at offset 0x0 returns the offset 0x4 value ANDed with the normal enable mask.
- R4: A normal-bank write at offset 0x8 sets each enable bit whose write data bit is 1 and leaves the others unchanged; a read at 0x8 returns the enable mask.
- R5: A normal-bank write at offset 0xC clears each enable bit whose write data bit is 1 and leaves the others unchanged.
- R6: A normal-bank write at offset 0x10 replaces the software register with the write data.
- R7: irq_n_o is 0 in the cycle after an edge at which normal masked status is nonzero, and 1 otherwise.
- R8: Fast bank: offset 0x4 reads the sampled fast line in bit 0 and 0 in bits 31:1; 0x0 reads that ANDed with the fast enable mask; 0x8 reads the mask and sets bits on write; 0xC clears bits on write; fiq_n_o is 0 in the cycle after an edge at which fast raw bit 0 and enable bit 0 are both 1.
- R9: Reads of normal offsets 0xC through 0x1C and fast offset 0xC return 0; writes to offsets 0x0, 0x4 and 0x14 through 0x1C change nothing. Address bits 1:0 are ignored.
- R10: A write to one bank never changes the state of the other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | General-purpose request lines, active high |
| fast_src_i | input | 1 | Fast request line, active high |
| nrm_addr_i | input | 5 | Normal bank byte address |
| nrm_we_i | input | 1 | Normal bank write enable |
| nrm_wdata_i | input | 32 | Normal bank write data |
| nrm_rdata_o | output | 32 | Normal bank read data (combinational) |
| fst_addr_i | input | 4 | Fast bank byte address |
| fst_we_i | input | 1 | Fast bank write enable |
| fst_wdata_i | input | 32 | Fast bank write data |
| fst_rdata_o | output | 32 | Fast bank read data (combinational) |
| irq_n_o | output | 1 | Normal interrupt request, active low |
| fiq_n_o | output | 1 | Fast interrupt request, active low |

## Verification
A wrong enable bit shows the same cycle on a read at offset 0x8 and within one edge on the request output whenever the matching source is active, so random set and clear traffic mixed with random sources exposes a corrupted mask within a few cycles. A stale or wrongly merged software register or sampling register shows at once at offset 0x4 and 0x0, and at the output one edge later. Reads of reserved offsets after every write pattern catch decode aliasing, and the other bank is read back after each write to catch cross-bank leakage.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_RAW,
    SEL_ENABLE,
    SEL_CLEAR,
    SEL_SOFT,
    SEL_NONE
  } reg_sel_e;

  // word index of each register; positions are software-visible
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_RAW    = 1;
  localparam int unsigned IDX_ENABLE = 2;
  localparam int unsigned IDX_CLEAR  = 3;
  localparam int unsigned IDX_SOFT   = 4;

  function automatic reg_sel_e decode_idx(input int unsigned idx, input bit has_soft);
    if (idx == IDX_STATUS)             return SEL_STATUS;
    if (idx == IDX_RAW)                return SEL_RAW;
    if (idx == IDX_ENABLE)             return SEL_ENABLE;
    if (idx == IDX_CLEAR)              return SEL_CLEAR;
    if (has_soft && idx == IDX_SOFT)   return SEL_SOFT;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/intc_sample.sv
module intc_sample #(
  parameter int unsigned W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SRC_W    = 32,
  parameter int unsigned AW       = 5,
  parameter bit          HAS_SOFT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_n_o
);
  localparam int unsigned IDX_W = AW - 2;

  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_byte_sel;
  reg_sel_e          sel;
  logic [DATA_W-1:0] en_q, soft_q, raw, masked;

  assign idx             = addr_i[AW-1:2];
  assign unused_byte_sel = addr_i[1:0];
  assign sel             = decode_idx(32'(idx), HAS_SOFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_ENABLE)     en_q <= en_q | wdata_i;
      else if (sel == SEL_CLEAR) en_q <= en_q & ~wdata_i;
    end
  end

  generate
    if (HAS_SOFT) begin : g_soft
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     soft_q <= '0;
        else if (we_i && sel == SEL_SOFT) soft_q <= wdata_i;
      end
    end else begin : g_no_soft
      assign soft_q = '0;
    end
  endgenerate

  assign raw    = DATA_W'(src_i) | soft_q;
  assign masked = raw & en_q;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = masked;
      SEL_RAW:    rdata_o = raw;
      SEL_ENABLE: rdata_o = en_q;
      default:    rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_n_o <= 1'b1;
    else         req_n_o <= ~|masked;
  end

  AST_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_ENABLE) |=> ((en_q & $past(wdata_i)) == $past(wdata_i))); // R4
  AST_SET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_ENABLE) |=> ((en_q & $past(en_q)) == $past(en_q))); // R4
  AST_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_CLEAR) |=> ((en_q & $past(wdata_i)) == '0)); // R5
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (sel == SEL_ENABLE || sel == SEL_CLEAR)) |=> $stable(en_q)); // R9
  AST_REQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw & en_q)) |=> !req_n_o); // R7
  AST_REQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(raw & en_q)) |=> req_n_o); // R7
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NRM_AW  = 5,
  parameter int unsigned FST_AW  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               fast_src_i,
  input  logic [NRM_AW-1:0]  nrm_addr_i,
  input  logic               nrm_we_i,
  input  logic [DATA_W-1:0]  nrm_wdata_i,
  output logic [DATA_W-1:0]  nrm_rdata_o,
  input  logic [FST_AW-1:0]  fst_addr_i,
  input  logic               fst_we_i,
  input  logic [DATA_W-1:0]  fst_wdata_i,
  output logic [DATA_W-1:0]  fst_rdata_o,
  output logic               irq_n_o,
  output logic               fiq_n_o
);
  localparam int unsigned SMP_W = NUM_SRC + 1;

  logic [SMP_W-1:0] smp_q;

  intc_sample #(.W(SMP_W)) u_sample (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fast_src_i, src_i}),
    .q_o   (smp_q)
  );

  intc_bank #(
    .DATA_W(DATA_W), .SRC_W(NUM_SRC), .AW(NRM_AW), .HAS_SOFT(1'b1)
  ) u_nrm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (smp_q[NUM_SRC-1:0]),
    .addr_i (nrm_addr_i),
    .we_i   (nrm_we_i),
    .wdata_i(nrm_wdata_i),
    .rdata_o(nrm_rdata_o),
    .req_n_o(irq_n_o)
  );

  intc_bank #(
    .DATA_W(DATA_W), .SRC_W(1), .AW(FST_AW), .HAS_SOFT(1'b0)
  ) u_fst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (smp_q[NUM_SRC]),
    .addr_i (fst_addr_i),
    .we_i   (fst_we_i),
    .wdata_i(fst_wdata_i),
    .rdata_o(fst_rdata_o),
    .req_n_o(fiq_n_o)
  );
endmodule

// File: tb/intc_dual_bank_bench.sv
module intc_dual_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic        fsrc = 1'b0;
  logic [4:0]  naddr = '0;
  logic        nwe = 1'b0;
  logic [31:0] nwd = '0;
  logic [31:0] nrd;
  logic [3:0]  faddr = '0;
  logic        fwe = 1'b0;
  logic [31:0] fwd = '0;
  logic [31:0] frd;
  logic        irq_n, fiq_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  intc_dual_bank u_intc_dual_bank (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .fast_src_i(fsrc),
    .nrm_addr_i(naddr), .nrm_we_i(nwe), .nrm_wdata_i(nwd), .nrm_rdata_o(nrm_rd_w),
    .fst_addr_i(faddr), .fst_we_i(fwe), .fst_wdata_i(fwd), .fst_rdata_o(frd),
    .irq_n_o(irq_n), .fiq_n_o(fiq_n)
  );
  logic [31:0] nrm_rd_w;
  assign nrd = nrm_rd_w;

  // bench model
  logic [31:0] m_src = '0, m_en = '0, m_soft = '0, m_fen = '0;
  logic        m_fsrc = 1'b0, m_irq_n = 1'b1, m_fiq_n = 1'b1;

  function automatic logic [31:0] exp_nrd(input logic [4:0] a);
    case (a[4:2])
      3'd0:    return (m_src | m_soft) & m_en;
      3'd1:    return m_src | m_soft;
      3'd2:    return m_en;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_frd(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return {31'b0, m_fsrc & m_fen[0]};
      2'd1:    return {31'b0, m_fsrc};
      2'd2:    return m_fen;
      default: return '0;
    endcase
  endfunction

  function automatic string ntag(input logic [4:0] a);
    case (a[4:2])
      3'd0: return "R3";
      3'd1: return "R2";
      3'd2: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational reads and outputs, advance model at edge
  task automatic cyc(input logic [31:0] s, input logic fs,
                     input logic nw, input logic [4:0] na, input logic [31:0] nd,
                     input logic fw, input logic [3:0] fa, input logic [31:0] fd,
                     input string ntg, input string ftg);
    src = s; fsrc = fs; nwe = nw; naddr = na; nwd = nd; fwe = fw; faddr = fa; fwd = fd;
    #1;
    check(nrd == exp_nrd(na), (ntg != "") ? ntg : ntag(na), nrd, exp_nrd(na));
    check(frd == exp_frd(fa), (ftg != "") ? ftg : ((fa[3:2] == 2'd3) ? "R9" : "R8"), frd, exp_frd(fa));
    check(irq_n == m_irq_n, "R7", {31'b0, irq_n}, {31'b0, m_irq_n});
    check(fiq_n == m_fiq_n, "R8", {31'b0, fiq_n}, {31'b0, m_fiq_n});
    @(posedge clk);
    m_irq_n = ~|((m_src | m_soft) & m_en);
    m_fiq_n = ~(m_fsrc & m_fen[0]);
    if (nw) begin
      case (na[4:2])
        3'd2: m_en = m_en | nd;
        3'd3: m_en = m_en & ~nd;
        3'd4: m_soft = nd;
        default: ;
      endcase
    end
    if (fw) begin
      case (fa[3:2])
        2'd2: m_fen = m_fen | fd;
        2'd3: m_fen = m_fen & ~fd;
        default: ;
      endcase
    end
    m_src = s; m_fsrc = fs;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    logic        fs;
    void'($urandom(32'd4242));
    // R1: reset state with active sources and writes attempted
    src = 32'hFFFF_FFFF; fsrc = 1'b1; nwe = 1'b1; naddr = 5'h08; nwd = '1;
    fwe = 1'b1; faddr = 4'h8; fwd = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq_n == 1'b1, "R1", {31'b0, irq_n}, 32'h1);
    check(fiq_n == 1'b1, "R1", {31'b0, fiq_n}, 32'h1);
    check(nrd == 32'h0, "R1", nrd, 32'h0);
    check(frd == 32'h0, "R1", frd, 32'h0);
    naddr = 5'h04; faddr = 4'h4; #1;
    check(nrd == 32'h0, "R1", nrd, 32'h0);
    check(frd == 32'h0, "R1", frd, 32'h0);
    src = '0; fsrc = 1'b0; nwe = 1'b0; fwe = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);

    // directed: set, clear, software register
    cyc(32'h0000_0011, 0, 1, 5'h08, 32'h0000_0001, 0, 4'h0, 0, "R4", "");
    cyc(32'h0000_0011, 0, 0, 5'h08, 0, 0, 4'h0, 0, "R4", "");
    cyc(32'h0000_0011, 0, 0, 5'h00, 0, 0, 4'h0, 0, "R3", "");
    cyc(32'h0000_0011, 0, 1, 5'h0C, 32'h0000_0001, 0, 4'h0, 0, "R3", "");
    cyc(32'h0000_0011, 0, 0, 5'h08, 0, 0, 4'h0, 0, "R5", "");
    cyc(32'h0000_0000, 0, 1, 5'h08, 32'h8000_0000, 0, 4'h0, 0, "", "");
    cyc(32'h0000_0000, 0, 1, 5'h10, 32'h8000_0001, 0, 4'h0, 0, "", "");
    cyc(32'h0000_0000, 0, 0, 5'h04, 0, 0, 4'h0, 0, "R6", "");
    cyc(32'h0000_0000, 0, 0, 5'h00, 0, 0, 4'h0, 0, "R6", "");
    cyc(32'h0000_0000, 0, 0, 5'h10, 0, 0, 4'h0, 0, "R9", "");
    // R9: writes to read-only and reserved offsets
    cyc(32'h0000_0000, 0, 1, 5'h00, 32'hFFFF_FFFF, 1, 4'h0, 32'hFFFF_FFFF, "", "");
    cyc(32'h0000_0000, 0, 1, 5'h04, 32'hFFFF_FFFF, 1, 4'h4, 32'hFFFF_FFFF, "", "");
    cyc(32'h0000_0000, 0, 1, 5'h1C, 32'hFFFF_FFFF, 0, 4'h8, 0, "R9", "R9");
    cyc(32'h0000_0000, 0, 0, 5'h08, 0, 0, 4'h8, 0, "R9", "R9");
    // R10: normal writes leave the fast bank alone and the reverse
    cyc(32'h0000_0000, 1, 1, 5'h08, 32'hFFFF_FFFF, 0, 4'h8, 0, "", "R10");
    cyc(32'h0000_0000, 1, 0, 5'h08, 0, 0, 4'h8, 0, "", "R10");
    cyc(32'h0000_0000, 1, 0, 5'h0C, 32'hFFFF_FFFF, 1, 4'h8, 32'h1, "", "");
    cyc(32'h0000_0000, 1, 1, 5'h0C, 32'hFFFF_FFFF, 0, 4'h0, 0, "R10", "R8");
    cyc(32'h0000_0000, 1, 0, 5'h08, 0, 0, 4'h8, 0, "R10", "R10");
    cyc(32'h0000_0000, 0, 0, 5'h00, 0, 1, 4'hC, 32'h1, "", "R9");
    cyc(32'h0000_0000, 0, 0, 5'h00, 0, 0, 4'h1, 0, "", "R9");

    // random traffic
    s = '0; fs = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] nd, fd;
      logic [4:0]  na;
      logic [3:0]  fa;
      logic        nw, fw;
      if ($urandom_range(3) == 0) s = $urandom() & $urandom();
      if ($urandom_range(3) == 0) fs = 1'(  $urandom_range(1));
      na = 5'($urandom_range(31));
      fa = 4'($urandom_range(15));
      nw = ($urandom_range(2) == 0);
      fw = ($urandom_range(2) == 0);
      nd = ($urandom_range(1) == 0) ? $urandom() : (32'h1 << $urandom_range(31));
      fd = ($urandom_range(1) == 0) ? $urandom() : 32'h1;
      if (na[4:2] == 3'd4 && $urandom_range(1) == 0) nd = '0;
      cyc(s, fs, nw, na, nd, fw, fa, fd, "", "");
    end
    finish_run();
  end
endmodule